// File: doc/BRIEF.md
# Random Word Output Buffer

This block buffers random data between a free-running pseudo-random generator and a 32-bit register read port. Entries are 64 bits wide and are produced on a fixed cycle cadence. Generation does not begin at reset. Software must first wait for the ready flag and then write the start register. From then on the buffer fills to its depth and is topped up again whenever software removes an entry.

Software drains the buffer through a single data register, two 32-bit reads per entry. An entry is removed only when its second half is read. If the pair is broken, or if a read finds the buffer empty, a sticky error bit is raised. The error bits clear only on a software reset. A software reset flushes the buffer, stops generation, reloads the generator seed and holds the ready flag low for a fixed number of cycles.

Control is a three-state machine:
- `ST_RESET` (not ready, buffer flushed) moves to `ST_IDLE` when the reset count expires.
- `ST_IDLE` (ready, no generation) moves to `ST_FILL` on a start write.
- `ST_FILL` (ready, generating) has no exit except reset.
- A software-reset write moves any state back to `ST_RESET`. A hardware reset also enters `ST_RESET`.

Top module: `rng_outbuf`

Register word addresses (`reg_addr`):
- 0: control. Writing bit 0 = 1 requests a software reset. Reads as 0.
- 1: status.
- 2: error status.
- 3: start. Any write starts generation.
- 4: data window.

## Requirements
- R1: After hardware reset or a software reset, the ready flag stays low while in `ST_RESET`, which lasts RST_CYCLES cycles. It then reads high. At that point the count reads 0, the error status reads 0 and `err_irq` is low.
- R2: No entry is generated until the start register is written while ready. A start write made while not ready is ignored.
- R3: After the start write, one entry is pushed every INTERVAL cycles. The first push lands INTERVAL clock edges after the edge that captured the write.
- R4: Pushes stop when the count reaches DEPTH. After software removes an entry, the next refill tick restores the count to DEPTH.
- R5: The status word holds the ready flag in bit 0 and the number of stored 64-bit entries in the field starting at bit 16. All other bits are 0.
- R6: Data-window reads return the low 32 bits of the head entry first and the high 32 bits second. The second read removes the entry. Entries, in order, are successive states of a 64-bit shift register seeded with 64'h0123456789ABCDEF, where each next state is `{s[62:0], s[63]^s[62]^s[60]^s[59]}`.
- R7: A data-window read with the buffer empty returns 0 and sets error-status bit 1 (underflow).
- R8: A register access other than a data-window read, made after a low-half read, sets error-status bit 0 (broken pair). The entry is not removed, and the next data read returns its low half again.
- R9: Error bits are sticky until a software reset. `err_irq` is the OR of the two bits.
- R10: A software reset empties the buffer and stops generation until the next start write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| err_irq | output | 1 | High while any error-status bit is set |

## Verification
The hardest state to reach from the ports is a full buffer losing one entry and being refilled on exactly the next tick. Reaching it takes the whole fill time, followed by a pop placed between two known tick edges. The stimulus counts clock edges from the start write, so it knows where every tick falls. This same edge counting lets the first push be checked to the exact cycle. The broken-pair case is reached by placing a status read between the two halves of a data read, then reading the data window again.

// File: rtl/rng_outbuf_pkg.sv
package rng_outbuf_pkg;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_IDLE  = 2'd1,
        ST_FILL  = 2'd2
    } rng_state_e;

    localparam int unsigned REG_AW = 3;

    localparam logic [REG_AW-1:0] ADDR_CTRL  = 3'd0;
    localparam logic [REG_AW-1:0] ADDR_STAT  = 3'd1;
    localparam logic [REG_AW-1:0] ADDR_ERR   = 3'd2;
    localparam logic [REG_AW-1:0] ADDR_START = 3'd3;
    localparam logic [REG_AW-1:0] ADDR_DATA  = 3'd4;

    localparam int unsigned STAT_CNT_LSB = 16;
    localparam int unsigned ERR_PAIR_BIT = 0;
    localparam int unsigned ERR_UFL_BIT  = 1;

endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
    parameter int unsigned     W    = 64,
    parameter logic [W-1:0]    SEED = 64'h0123_4567_89AB_CDEF,
    parameter logic [W-1:0]    TAPS = 64'hD800_0000_0000_0000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reload,
    input  logic         advance,
    output logic [W-1:0] value
);

    logic feedback;

    assign feedback = ^(value & TAPS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= SEED;
        end else if (reload) begin
            value <= SEED;
        end else if (advance) begin
            value <= {value[W-2:0], feedback};
        end
    end

    // R6: the generator never collapses to the all-zero lock-up state
    a_r6_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        value != '0);

endmodule

// File: rtl/rng_refill_timer.sv
module rng_refill_timer #(
    parameter int unsigned INTERVAL = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic tick
);

    localparam int unsigned CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt;

    assign tick = enable && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!enable || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3: ticks are never back to back
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/rng_fifo.sv
module rng_fifo #(
    parameter int unsigned W     = 64,
    parameter int unsigned DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);

    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic          do_push;
    logic          do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign head    = mem[rd_ptr];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R4: occupancy never exceeds the depth
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R4: the refill source never offers an entry to a full buffer
    a_r4_push_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

endmodule

// File: rtl/rng_outbuf.sv
module rng_outbuf
    import rng_outbuf_pkg::*;
#(
    parameter int unsigned  DEPTH      = 8,
    parameter int unsigned  INTERVAL   = 256,
    parameter int unsigned  RST_CYCLES = 8,
    parameter logic [63:0]  SEED       = 64'h0123_4567_89AB_CDEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              err_irq
);

    localparam int unsigned ENTRY_W = 64;
    localparam int unsigned HALF_W  = ENTRY_W / 2;
    localparam int unsigned CNT_W   = $clog2(DEPTH + 1);
    localparam int unsigned RCW     = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [RCW-1:0] RST_LAST = RCW'(RST_CYCLES - 1);

    rng_state_e state;
    rng_state_e state_nxt;

    logic [RCW-1:0]     rst_cnt;
    logic               rst_done;
    logic               soft_rst_wr;
    logic               start_wr;
    logic               data_rd;
    logic               any_access;

    logic               ready;
    logic               timer_en;
    logic               fifo_flush;
    logic               lfsr_reload;

    logic               tick;
    logic               push;
    logic               pop;
    logic [ENTRY_W-1:0] gen_value;
    logic [ENTRY_W-1:0] head;
    logic [CNT_W-1:0]   fifo_count;
    logic               fifo_full;
    logic               fifo_empty;

    logic               half_pend;
    logic               err_pair;
    logic               err_ufl;
    logic [31:0]        stat_word;
    logic [31:0]        err_word;
    logic               unused_wdata;

    assign unused_wdata = ^reg_wdata[31:1];

    // Register access decode
    assign any_access  = reg_wr || reg_rd;
    assign data_rd     = reg_rd && (reg_addr == ADDR_DATA);
    assign soft_rst_wr = reg_wr && (reg_addr == ADDR_CTRL) && reg_wdata[0];
    assign start_wr    = reg_wr && (reg_addr == ADDR_START);
    assign rst_done    = (rst_cnt == RST_LAST);

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RESET: if (rst_done) state_nxt = ST_IDLE;
            ST_IDLE:  if (start_wr) state_nxt = ST_FILL;
            ST_FILL:  state_nxt = ST_FILL;
            default:  state_nxt = ST_RESET;
        endcase
        if (soft_rst_wr) begin
            state_nxt = ST_RESET;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RESET;
        end else begin
            state <= state_nxt;
        end
    end

    // Reset-hold counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_cnt <= '0;
        end else if (soft_rst_wr || state != ST_RESET) begin
            rst_cnt <= '0;
        end else if (!rst_done) begin
            rst_cnt <= rst_cnt + 1'b1;
        end
    end

    // State-decoded outputs
    always_comb begin
        ready       = 1'b1;
        timer_en    = 1'b0;
        fifo_flush  = 1'b0;
        lfsr_reload = 1'b0;
        unique case (state)
            ST_RESET: begin
                ready       = 1'b0;
                fifo_flush  = 1'b1;
                lfsr_reload = 1'b1;
            end
            ST_IDLE: begin
                ready = 1'b1;
            end
            ST_FILL: begin
                timer_en = 1'b1;
            end
            default: begin
                ready = 1'b0;
            end
        endcase
    end

    assign push = tick && !fifo_full;
    assign pop  = data_rd && half_pend && !fifo_empty && !fifo_flush;

    rng_refill_timer #(
        .INTERVAL (INTERVAL)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (timer_en),
        .tick   (tick)
    );

    rng_lfsr #(
        .W    (ENTRY_W),
        .SEED (SEED),
        .TAPS (64'hD800_0000_0000_0000)
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (lfsr_reload),
        .advance (push),
        .value   (gen_value)
    );

    rng_fifo #(
        .W     (ENTRY_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (fifo_flush),
        .push      (push),
        .push_data (gen_value),
        .pop       (pop),
        .head      (head),
        .count     (fifo_count),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    // Status and error words
    always_comb begin
        stat_word = '0;
        stat_word[0] = ready;
        stat_word[STAT_CNT_LSB +: CNT_W] = fifo_count;
        err_word = '0;
        err_word[ERR_PAIR_BIT] = err_pair;
        err_word[ERR_UFL_BIT]  = err_ufl;
    end

    // Half-word sequencing and sticky errors
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_pend <= 1'b0;
            err_pair  <= 1'b0;
            err_ufl   <= 1'b0;
        end else if (state == ST_RESET || soft_rst_wr) begin
            half_pend <= 1'b0;
            err_pair  <= 1'b0;
            err_ufl   <= 1'b0;
        end else if (data_rd) begin
            if (fifo_empty) begin
                err_ufl <= 1'b1;
            end else begin
                half_pend <= !half_pend;
            end
        end else if (half_pend && any_access) begin
            err_pair  <= 1'b1;
            half_pend <= 1'b0;
        end
    end

    // Read data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            unique case (reg_addr)
                ADDR_STAT: reg_rdata <= stat_word;
                ADDR_ERR:  reg_rdata <= err_word;
                ADDR_DATA: begin
                    if (fifo_empty) begin
                        reg_rdata <= '0;
                    end else if (half_pend) begin
                        reg_rdata <= head[ENTRY_W-1:HALF_W];
                    end else begin
                        reg_rdata <= head[HALF_W-1:0];
                    end
                end
                default:   reg_rdata <= '0;
            endcase
        end
    end

    assign err_irq = err_pair || err_ufl;

    // R10: a software-reset write always lands in the reset state
    a_r10_soft_reset_enters: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_wr |=> (state == ST_RESET));

    // R7: an empty data read raises the underflow bit
    a_r7_underflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && fifo_empty && state != ST_RESET && !soft_rst_wr) |=> err_ufl);

    // R9: error bits stay set until a software reset
    a_r9_sticky_ufl: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ufl && !soft_rst_wr) |=> err_ufl);
    a_r9_sticky_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pair && !soft_rst_wr) |=> err_pair);

    // R2: occupancy cannot grow outside the filling state
    a_r2_no_growth_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_FILL) |=> (fifo_count <= $past(fifo_count)));

    // R6: an entry leaves only after its low half has been read
    a_r6_pop_on_second: assert property (@(posedge clk) disable iff (!rst_n)
        (!half_pend && state != ST_RESET) |=> (fifo_count >= $past(fifo_count)));

endmodule

// File: tb/rng_outbuf_tb.sv
module rng_outbuf_tb;

    localparam int unsigned DEPTH      = 8;
    localparam int unsigned INTERVAL   = 256;
    localparam int unsigned RST_CYCLES = 8;
    localparam logic [63:0] SEED       = 64'h0123_4567_89AB_CDEF;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_STAT  = 3'd1;
    localparam logic [2:0] A_ERR   = 3'd2;
    localparam logic [2:0] A_START = 3'd3;
    localparam logic [2:0] A_DATA  = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        err_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [63:0] model;

    always #2.5 clk = ~clk;

    rng_outbuf #(
        .DEPTH      (DEPTH),
        .INTERVAL   (INTERVAL),
        .RST_CYCLES (RST_CYCLES),
        .SEED       (SEED)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .err_irq   (err_irq)
    );

    function automatic logic [63:0] nxt(input logic [63:0] s);
        return {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic soft_reset();
        logic [31:0] v;
        wr(A_CTRL, 32'h1);
        rd(A_STAT, v);
        chk("R1 ready low in reset", {31'd0, v[0]}, 32'd0);
        wait_cyc(RST_CYCLES + 2);
        model = SEED;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        rst_n = 1'b1;
        rd(A_STAT, v);
        chk("R1 ready low after hw reset", {31'd0, v[0]}, 32'd0);
        wait_cyc(RST_CYCLES + 2);
        rd(A_STAT, v);
        chk("R5 R1 status word ready, count 0", v, 32'h0000_0001);
        rd(A_ERR, v);
        chk("R1 error status clear", v, 32'd0);
        chk("R1 err_irq low", {31'd0, err_irq}, 32'd0);
        model = SEED;
    endtask

    task automatic t_no_start();
        logic [31:0] v;
        wait_cyc(600);
        rd(A_STAT, v);
        chk("R2 no generation before start", v, 32'h0000_0001);
        wr(A_CTRL, 32'h1);
        wr(A_START, 32'h8);
        wait_cyc(RST_CYCLES + 600);
        rd(A_STAT, v);
        chk("R2 start while not ready ignored", v, 32'h0000_0001);
    endtask

    task automatic t_cadence();
        logic [31:0] v;
        wr(A_START, 32'h8);
        wait_cyc(INTERVAL - 1);
        rd(A_STAT, v);
        chk("R3 no entry one edge early", v, 32'h0000_0001);
        rd(A_STAT, v);
        chk("R3 first entry at interval", v, 32'h0001_0001);
        wait_cyc(INTERVAL);
        rd(A_STAT, v);
        chk("R3 second entry one interval later", v, 32'h0002_0001);
    endtask

    task automatic t_order();
        logic [31:0] v;
        wait_cyc(INTERVAL);
        for (int i = 0; i < 3; i++) begin
            rd(A_DATA, v);
            chk("R6 low half first", v, model[31:0]);
            rd(A_DATA, v);
            chk("R6 high half second", v, model[63:32]);
            model = nxt(model);
        end
        rd(A_ERR, v);
        chk("R6 paired reads raise no error", v, 32'd0);
    endtask

    task automatic t_full();
        logic [31:0] v;
        soft_reset();
        wr(A_START, 32'h8);
        wait_cyc(DEPTH * INTERVAL + 50);
        rd(A_STAT, v);
        chk("R4 fills to depth", v[31:16], 32'(DEPTH));
        wait_cyc(600);
        rd(A_STAT, v);
        chk("R4 stays at depth", v[31:16], 32'(DEPTH));
        rd(A_DATA, v);
        rd(A_DATA, v);
        rd(A_STAT, v);
        chk("R4 R6 pop on second half", v[31:16], 32'(DEPTH - 1));
        wait_cyc(INTERVAL + 1);
        rd(A_STAT, v);
        chk("R4 refilled to depth", v[31:16], 32'(DEPTH));
    endtask

    task automatic t_flush();
        logic [31:0] v;
        soft_reset();
        rd(A_STAT, v);
        chk("R10 flushed by soft reset", v, 32'h0000_0001);
        wait_cyc(600);
        rd(A_STAT, v);
        chk("R10 generation stopped", v, 32'h0000_0001);
    endtask

    task automatic t_underflow();
        logic [31:0] v;
        rd(A_DATA, v);
        chk("R7 empty read returns zero", v, 32'd0);
        rd(A_ERR, v);
        chk("R7 underflow bit 1 set", v, 32'h2);
        chk("R9 err_irq high", {31'd0, err_irq}, 32'd1);
        wait_cyc(20);
        rd(A_STAT, v);
        rd(A_ERR, v);
        chk("R9 underflow sticky", v, 32'h2);
        soft_reset();
        rd(A_ERR, v);
        chk("R9 soft reset clears errors", v, 32'd0);
        chk("R9 err_irq low after reset", {31'd0, err_irq}, 32'd0);
    endtask

    task automatic t_half();
        logic [31:0] v;
        wr(A_START, 32'h8);
        wait_cyc(INTERVAL + 40);
        rd(A_DATA, v);
        chk("R8 low half read", v, model[31:0]);
        rd(A_STAT, v);
        chk("R8 entry kept during pair", v[31:16], 32'd1);
        rd(A_ERR, v);
        chk("R8 broken pair bit 0 set", v, 32'h1);
        rd(A_DATA, v);
        chk("R8 low half again", v, model[31:0]);
        rd(A_DATA, v);
        chk("R8 then high half", v, model[63:32]);
        rd(A_STAT, v);
        chk("R8 entry removed", v[31:16], 32'd0);
    endtask

    initial begin
        wait_cyc(3);
        t_reset();
        t_no_start();
        t_cadence();
        t_order();
        t_full();
        t_flush();
        t_underflow();
        t_half();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule